// File: doc/BRIEF.md
# Single-wire debug command sequencer

This block is the host-side engine of a single-wire background debug link. A local requester hands it one command at a time: a command class, an 8-bit opcode, a 16-bit address and 16-bit write data. The block turns that request into a serial frame on an open-drain line that rests high. It sends the fields in the order that the command class calls for and waits for a fixed number of bus clocks after the outgoing fields. For read classes it then clocks 16 data bits back from the target and returns them with a one-cycle done strobe.

Bit timing is counted in target clocks. One target clock is `TC_DIV` local clocks. The mandatory delays are counted in bus clocks, and one bus clock is `BC_DIV` local clocks. The line has two separate ports. `line_oe` pulls the wire low when it is high, and `line_in` carries the sampled wire level. A board model or a bench can therefore play the part of the target.

Top module: `bgline_cmd_seq`

## Requirements
- R1: After reset, `line_oe`, `busy` and `done` are all 0 and `rdata` is 0.
- R2: Every serial bit lasts 16 target clocks and begins when the host starts pulling the line low. A transmitted 1 is pulled low for 4 target clocks and a transmitted 0 for 13 target clocks. Each field is sent most-significant bit first.
- R3: `req_kind` picks the frame layout, using this encoding. 0 is a hardware read: opcode then address. 1 is a hardware write: opcode, address, then write data. 2 is a firmware read: opcode only. 3 is a firmware write: opcode then write data. Any value from 4 to 7 is a go/trace command: opcode only.
- R4: Hardware read and hardware write wait 150 bus clocks after their last outgoing bit.
- R5: Firmware read waits 48 bus clocks and firmware write waits 36 bus clocks after their last outgoing bit.
- R6: A go/trace command keeps the line idle for 76 bus clocks after its opcode before the block will accept another request.
- R7: After its delay, a read class clocks in 16 bits. For each bit the host pulls the line low for 2 target clocks, then samples `line_in` at the start of target clock 8 of the bit. The bits are assembled MSB first into `rdata`. `rdata` changes only when a read completes.
- R8: `done` is a one-cycle pulse, and `busy` falls in that same cycle. Measured from the first cycle of the frame's first bit, `done` arrives 16·TC_DIV·(outgoing bits + incoming bits) + delay·BC_DIV cycles later.
- R9: A request is accepted when `req_valid` is high while `busy` is low. `busy` rises in the next cycle. A request presented while `busy` is high is ignored: it produces no extra frame and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 3 | Command class (see R3) |
| req_op | input | 8 | Opcode byte |
| req_addr | input | 16 | Address field |
| req_wdata | input | 16 | Write data field |
| busy | output | 1 | High from acceptance until the frame ends |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last value read from the target |
| line_oe | output | 1 | High pulls the debug line low |
| line_in | input | 1 | Sampled debug line level |

## Verification
The bench acts as the target. It times each low pulse on `line_oe` in local cycles: a width of 4·TC_DIV means 1 and 13·TC_DIV means 0. It also expects consecutive bit starts exactly 16·TC_DIV cycles apart. For reads, the gap from the last outgoing bit start to the first incoming bit start must be 16·TC_DIV plus the class delay in local cycles. `done` must appear exactly at the R8 count after the first bit start. All timing is taken from a cycle counter sampled on falling clock edges, so each check lands in the cycle its result is due. During reads the target pulls the line low through the sample point for each 0 bit. The returned word is compared with the queued expectation when `done` pulses.

// File: rtl/bgline_cmd_seq.sv
module bgline_cmd_seq #(
  parameter int TC_DIV = 4,
  parameter int BC_DIV = 2,
  parameter int CNT_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [7:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        line_oe,
  input  logic        line_in
);
  localparam int TDIV_W   = $clog2(TC_DIV + 1);
  localparam int FRAME_W  = 40;
  localparam int BIT_TC   = 16;
  localparam int ONE_LOW  = 4;
  localparam int ZERO_LOW = 13;
  localparam int RD_LOW   = 2;
  localparam int RD_SMP   = 8;
  localparam int DLY_HW   = 150;
  localparam int DLY_FRD  = 48;
  localparam int DLY_FWR  = 36;
  localparam int DLY_GO   = 76;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_RX} state_t;

  function automatic int tx_bits(input logic [2:0] k);
    case (k)
      3'd0: return 24;
      3'd1: return 40;
      3'd2: return 8;
      3'd3: return 24;
      default: return 8;
    endcase
  endfunction

  function automatic int delay_bc(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: return DLY_HW;
      3'd2:       return DLY_FRD;
      3'd3:       return DLY_FWR;
      default:    return DLY_GO;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] frame_of(input logic [2:0] k, input logic [7:0] op,
                                                  input logic [15:0] a, input logic [15:0] w);
    case (k)
      3'd0:    return {op, a, 16'h0};
      3'd1:    return {op, a, w};
      3'd3:    return {op, w, 16'h0};
      default: return {op, 32'h0};
    endcase
  endfunction

  state_t              state;
  logic [2:0]          kind_q;
  logic [FRAME_W-1:0]  shreg;
  logic [5:0]          bitcnt;
  logic [TDIV_W-1:0]   tdiv;
  logic [3:0]          phase;
  logic [CNT_W-1:0]    wcnt;
  logic [15:0]         rshift;

  wire tick     = (tdiv == TDIV_W'(TC_DIV - 1));
  wire bit_end  = tick && (phase == 4'(BIT_TC - 1));
  wire sample   = (state == S_RX) && (phase == 4'(RD_SMP)) && (tdiv == '0);
  wire is_read  = (kind_q == 3'd0) || (kind_q == 3'd2);
  wire serial   = (state == S_TX) || (state == S_RX);

  assign busy = (state != S_IDLE);

  always_comb begin
    case (state)
      S_TX:    line_oe = phase < (shreg[FRAME_W-1] ? 4'(ONE_LOW) : 4'(ZERO_LOW));
      S_RX:    line_oe = phase < 4'(RD_LOW);
      default: line_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= '0;
      shreg  <= '0;
      bitcnt <= '0;
      tdiv   <= '0;
      phase  <= '0;
      wcnt   <= '0;
      rshift <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (serial) begin
        tdiv <= tick ? '0 : tdiv + 1'b1;
        if (tick) phase <= phase + 1'b1;
      end else begin
        tdiv  <= '0;
        phase <= '0;
      end
      if (sample) rshift <= {rshift[14:0], line_in};
      case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_TX;
          kind_q <= req_kind;
          shreg  <= frame_of(req_kind, req_op, req_addr, req_wdata);
          bitcnt <= 6'(tx_bits(req_kind) - 1);
        end
        S_TX: if (bit_end) begin
          shreg <= shreg << 1;
          if (bitcnt == '0) begin
            state <= S_WAIT;
            wcnt  <= CNT_W'(delay_bc(kind_q) * BC_DIV - 1);
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        S_WAIT: begin
          if (wcnt == '0) begin
            if (is_read) begin
              state  <= S_RX;
              bitcnt <= 6'd15;
            end else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_RX: if (bit_end) begin
          if (bitcnt == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
            rdata <= rshift;
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !line_oe); // R1
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
  AST_ACCEPT:        assert property (@(posedge clk) disable iff (!rst_n) (!busy && req_valid) |=> busy); // R9
  AST_BUSY_KEEP:     assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |-> $past(busy || req_valid)); // R9
  AST_RDATA_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rdata)); // R7
  AST_WAIT_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (state == S_WAIT) |-> !line_oe); // R4
endmodule

// File: tb/bgline_cmd_seq_bench.sv
module bgline_cmd_seq_bench;
  localparam int TC = 2;
  localparam int BC = 3;
  localparam int BT = 16 * TC;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_kind = 0;
  logic [7:0] req_op = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic busy, done, line_oe, line_in;
  logic [15:0] rdata;
  logic tgt_low = 0;

  assign line_in = ~(line_oe | tgt_low);
  always #5 clk = ~clk;

  bgline_cmd_seq #(.TC_DIV(TC), .BC_DIV(BC)) u_bgline_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .line_oe(line_oe), .line_in(line_in));

  typedef struct {
    int txn; logic [39:0] tx; int rxn; logic [15:0] rx; int dly; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] last_read = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor / target model
  int cyc = 0, edge_i = 0, first_cyc = 0, last_start = 0, bit_start = 0, tgt_cnt = 0;
  logic prev_oe = 0;
  logic [39:0] got_tx = 0;
  always @(negedge clk) begin
    cyc++;
    if (tgt_cnt > 0) begin
      tgt_cnt--;
      if (tgt_cnt == 0) tgt_low = 0;
    end
    if (rst_n && line_oe && !prev_oe) begin
      if (q.size() == 0) chk(0, "R9 frame without request", 1, 0);
      else begin
        if (edge_i == 0) first_cyc = cyc;
        else if (edge_i == q[0].txn)
          chk(cyc - last_start == BT + q[0].dly * BC, {"R4/R5 read gap ", q[0].tag}, cyc - last_start, BT + q[0].dly * BC);
        else
          chk(cyc - last_start == BT, "R2 bit period", cyc - last_start, BT);
        if (edge_i >= q[0].txn) begin
          tgt_low = !q[0].rx[15 - (edge_i - q[0].txn)];
          tgt_cnt = 10 * TC;
        end
        bit_start = cyc;
        last_start = cyc;
        edge_i++;
      end
    end
    if (rst_n && !line_oe && prev_oe && q.size() > 0 && edge_i <= q[0].txn) begin
      chk((cyc - bit_start == 4 * TC) || (cyc - bit_start == 13 * TC), "R2 low width", cyc - bit_start, 4 * TC);
      got_tx = {got_tx[38:0], (cyc - bit_start) < 8 * TC};
    end
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R9 done without request", 1, 0);
      else begin
        exp_t e;
        logic [39:0] mask;
        e = q.pop_front();
        mask = (40'd1 << e.txn) - 1;
        chk(edge_i == e.txn + e.rxn, {"R3 bit count ", e.tag}, edge_i, e.txn + e.rxn);
        chk((got_tx & mask) == e.tx, {"R2/R3 frame ", e.tag}, got_tx & mask, e.tx);
        chk(cyc - first_cyc == BT * (e.txn + e.rxn) + e.dly * BC,
            {"R8 latency (R4 R5 R6) ", e.tag}, cyc - first_cyc, BT * (e.txn + e.rxn) + e.dly * BC);
        chk(!busy, "R8 busy falls with done", busy, 0);
        if (e.rxn > 0) begin
          chk(rdata == e.rx, {"R7 read data ", e.tag}, rdata, e.rx);
          last_read = e.rx;
        end else
          chk(rdata == last_read, {"R7 rdata held ", e.tag}, rdata, last_read);
      end
      edge_i = 0;
      got_tx = 0;
    end
    prev_oe = line_oe;
  end

  task automatic send(input logic [2:0] k, input logic [7:0] op, input logic [15:0] a,
                      input logic [15:0] w, input logic [15:0] rv, input string tag, input bit poke);
    exp_t e;
    case (k)
      3'd0: begin e.tx = {16'h0, op, a}; e.txn = 24; e.rxn = 16; e.dly = 150; end
      3'd1: begin e.tx = {op, a, w};     e.txn = 40; e.rxn = 0;  e.dly = 150; end
      3'd2: begin e.tx = {32'h0, op};    e.txn = 8;  e.rxn = 16; e.dly = 48;  end
      3'd3: begin e.tx = {16'h0, op, w}; e.txn = 24; e.rxn = 0;  e.dly = 36;  end
      default: begin e.tx = {32'h0, op}; e.txn = 8; e.rxn = 0;  e.dly = 76;  end
    endcase
    e.rx = rv; e.tag = tag;
    @(negedge clk);
    while (busy) @(negedge clk);
    q.push_back(e);
    req_kind = k; req_op = op; req_addr = a; req_wdata = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R9 busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_kind = 3'd2; req_op = 8'hFF; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk(busy, "R9 busy during ignored request", busy, 1);
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!line_oe && !busy && !done && rdata == 0, "R1 reset state", {line_oe, busy, done, rdata}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!line_oe && !busy, "R1 idle after reset", {line_oe, busy}, 0);
    send(3'd0, 8'hE4, 16'h1234, 16'h0, 16'hA55A, "hw read", 0);
    send(3'd1, 8'hC2, 16'h8001, 16'h5AC3, 16'h0, "hw write ignored req", 1);
    send(3'd2, 8'hE0, 16'h0, 16'h0, 16'h0FF0, "fw read", 0);
    send(3'd3, 8'h41, 16'h0, 16'hBEEF, 16'h0, "fw write", 0);
    send(3'd4, 8'h08, 16'h0, 16'h0, 16'h0, "go", 0);
    send(3'd7, 8'h10, 16'h0, 16'h0, 16'h0, "trace", 0);
    send(3'd0, 8'hFF, 16'hFFFF, 16'h0, 16'hFFFF, "hw read ones", 0);
    send(3'd2, 8'h00, 16'h0, 16'h0, 16'h0000, "fw read zeros", 0);
    send(3'd1, 8'h00, 16'h0000, 16'hFFFF, 16'h0, "hw write edge", 0);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 all frames completed", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule